// File: doc/BRIEF.md
# Burst Refill Read Controller

This block runs the read side of a shared 32-bit address/data bus. The processor side offers one read request at a time. Each request carries a word address, byte lanes, a flag saying whether it comes from a cache miss, and a flag saying whether the miss was an instruction fetch. The block decides whether the request becomes one single-word read or a four-word burst refill. It then drives a one-cycle address phase on the shared bus with a latch strobe and releases the bus for one turnaround cycle. After that it opens the data phase, in which it captures words on a data strobe and finishes on an acknowledge.

Captured words are held in a small read buffer. Once the memory has acknowledged, the buffered words are handed to a cache-fill port in word order, together with byte parity and a tag parity bit. Two probe outputs report the cause of the transfer during the address phase. For the rest of the read, they report the low word-address bits.

Top module: `rdfill_ctrl`

## Requirements
- R1: One clock edge after a request is accepted, `addr_strobe` and `bus_ad_oe` are high for exactly one cycle. During that cycle `bus_ad_out` carries request address bits 31:4 in bits 31:4 and the four byte lanes in bits 3:0.
- R2: `burst_req` is high from the address phase until the read ends. It is high only when `req_miss` is 1 and at least one of `req_imiss` or `cfg_dquad` is 1, using the values sampled at acceptance.
- R3: `word_addr` shows request address bits 3:2 for the whole of a single read. In a burst it starts at 00 and increments on each captured word, wrapping from 11 to 00. It is 00 whenever no read is in progress and during the fill.
- R4: Each `word_strobe` cycle in the data phase writes `bus_ad_in` into the buffer. In a burst the slot is the current `word_addr`; in a single read it is slot 0. The read ends only on `ack`, and nothing reaches the fill port before `ack`.
- R5: After `ack`, `fill_valid` is high for four cycles in a burst, with `fill_idx` 0,1,2,3 and the matching captured words. In a single read it is high for one cycle with `fill_idx` equal to address bits 3:2. In every fill cycle, `fill_par[i]` is the XOR of byte i of `fill_data`, and `fill_tag_par` is the XOR of address bits 31:12.
- R6: `bus_err` in the data phase ends the read at once. `berr_flag` is then high for one cycle while `busy` is 0, and no fill follows. `bus_err` outside the data phase has no effect.
- R7: During the address phase, `probe_hi` equals `req_miss` and `probe_lo` equals `req_imiss` (1 = instruction). For the rest of the read they show address bits 3 and 2. They are 0 when no read is in progress.
- R8: `rd_enable` is high only in the data phase. It is never high in the same cycle as `bus_ad_oe`, and a turnaround cycle with both low separates the two phases.
- R9: `req_valid` is ignored while `busy` is high; a request held high during a read neither restarts nor changes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken when idle |
| req_addr | input | 30 | Word address, bits 31:2 |
| req_be | input | 4 | Byte lanes for the address phase |
| req_miss | input | 1 | Read caused by a cache miss |
| req_imiss | input | 1 | 1 = instruction fetch, 0 = data |
| cfg_dquad | input | 1 | Data misses refill four words |
| busy | output | 1 | Read or fill in progress |
| bus_ad_out | output | 32 | Shared bus value in the address phase |
| bus_ad_oe | output | 1 | Block drives the shared bus |
| bus_ad_in | input | 32 | Shared bus value from memory |
| addr_strobe | output | 1 | Address latch strobe |
| burst_req | output | 1 | Four-word burst requested |
| word_addr | output | 2 | Low word-address counter |
| word_strobe | input | 1 | Capture current bus word |
| ack | input | 1 | Memory has finished the read |
| bus_err | input | 1 | Bus error from memory |
| rd_enable | output | 1 | Memory may drive the bus |
| probe_hi | output | 1 | Miss flag, then address bit 3 |
| probe_lo | output | 1 | Instruction flag, then address bit 2 |
| berr_flag | output | 1 | Read ended by bus error |
| fill_valid | output | 1 | Fill word valid |
| fill_idx | output | 2 | Word index of the fill word |
| fill_data | output | 32 | Fill word |
| fill_par | output | 4 | Byte parity of the fill word |
| fill_tag_par | output | 1 | Parity of the tag bits |

## Verification
The hardest case to reach is the counter wrap. It only shows on the ports when memory delivers the fourth word and then waits at least one cycle before acknowledging. The stimulus therefore draws, for each burst, whether the acknowledge comes with the last strobe or after it, and it checks the counter in the gap. Bus errors in the middle of a burst and requests held high across a whole read are drawn in the same way, next to directed cases for each combination of miss type and refill mode.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_TURN,
      ST_DATA,
      ST_FILL
   } rbc_state_e;

   typedef struct packed {
      logic [31:2] addr;
      logic [3:0]  be;
      logic        miss;
      logic        imiss;
      logic        burst;
   } rbc_req_t;
endpackage

// File: rtl/rbc_wcnt.sv
module rbc_wcnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (step)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rbc_rbuf.sv
module rbc_rbuf #(
   parameter int DW      = 32,
   parameter int DEPTH   = 4,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [DW-1:0]            wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DW-1:0]            rd_data,
   output logic [DW/8-1:0]          rd_par
);
   localparam int NB = DW / 8;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign rd_par[g] = (^rd_data[g*8 +: 8]) ^ ODD_PAR;
   end
endmodule

// File: rtl/rbc_phase_mux.sv
module rbc_phase_mux
   import rbc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          in_addr,
   input  logic          in_word,
   input  rbc_req_t      req,
   output logic [DW-1:0] ad_out,
   output logic          probe_hi,
   output logic          probe_lo
);
   always_comb begin
      ad_out   = '0;
      probe_hi = 1'b0;
      probe_lo = 1'b0;
      if (in_addr) begin
         ad_out   = {req.addr[31:4], req.be};
         probe_hi = req.miss;
         probe_lo = req.imiss;
      end else if (in_word) begin
         probe_hi = req.addr[3];
         probe_lo = req.addr[2];
      end
   end
endmodule

// File: rtl/rdfill_ctrl.sv
module rdfill_ctrl
   import rbc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DEPTH   = 4,
   parameter int TAG_LSB = 12,
   parameter bit ODD_PAR = 1'b0,
   localparam int CW     = $clog2(DEPTH),
   localparam int NB     = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [31:2]   req_addr,
   input  logic [NB-1:0] req_be,
   input  logic          req_miss,
   input  logic          req_imiss,
   input  logic          cfg_dquad,
   output logic          busy,
   output logic [DW-1:0] bus_ad_out,
   output logic          bus_ad_oe,
   input  logic [DW-1:0] bus_ad_in,
   output logic          addr_strobe,
   output logic          burst_req,
   output logic [CW-1:0] word_addr,
   input  logic          word_strobe,
   input  logic          ack,
   input  logic          bus_err,
   output logic          rd_enable,
   output logic          probe_hi,
   output logic          probe_lo,
   output logic          berr_flag,
   output logic          fill_valid,
   output logic [CW-1:0] fill_idx,
   output logic [DW-1:0] fill_data,
   output logic [NB-1:0] fill_par,
   output logic          fill_tag_par
);
   initial begin
      if (DW != 32)
         $fatal(1, "rdfill_ctrl: address phase layout needs DW of 32");
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "rdfill_ctrl: DEPTH must be a power of two of at least 4");
      if (TAG_LSB < 4 || TAG_LSB > 31)
         $fatal(1, "rdfill_ctrl: TAG_LSB out of range");
   end

   rbc_state_e state_q, state_d;
   rbc_req_t   req_q;
   logic       berr_q;

   logic          accept, in_data, cap, end_ok, end_err, last_fill, burst_new;
   logic [CW-1:0] wcnt, fcnt, wr_idx;

   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign in_data   = (state_q == ST_DATA);
   assign cap       = in_data && word_strobe && !bus_err;
   assign end_ok    = in_data && ack && !bus_err;
   assign end_err   = in_data && bus_err;
   assign burst_new = req_miss && (req_imiss || cfg_dquad);
   assign last_fill = req_q.burst ? (fcnt == CW'(DEPTH - 1)) : 1'b1;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ADDR;
         ST_ADDR: state_d = ST_TURN;
         ST_TURN: state_d = ST_DATA;
         ST_DATA: begin
            if (bus_err)  state_d = ST_IDLE;
            else if (ack) state_d = ST_FILL;
         end
         ST_FILL: if (last_fill) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         req_q   <= '0;
         berr_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         berr_q  <= end_err;
         if (accept) begin
            req_q.addr  <= req_addr;
            req_q.be    <= req_be;
            req_q.miss  <= req_miss;
            req_q.imiss <= req_imiss;
            req_q.burst <= burst_new;
         end
      end
   end

   rbc_wcnt #(.CW(CW)) u_word_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (end_ok || end_err),
      .load     (accept),
      .load_val (burst_new ? '0 : req_addr[CW+1:2]),
      .step     (cap && req_q.burst),
      .cnt      (wcnt)
   );

   rbc_wcnt #(.CW(CW)) u_fill_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .load     (1'b0),
      .load_val ('0),
      .step     (state_q == ST_FILL),
      .cnt      (fcnt)
   );

   assign wr_idx = req_q.burst ? wcnt : '0;

   rbc_rbuf #(.DW(DW), .DEPTH(DEPTH), .ODD_PAR(ODD_PAR)) u_rbuf (
      .clk     (clk),
      .wr_en   (cap),
      .wr_idx  (wr_idx),
      .wr_data (bus_ad_in),
      .rd_idx  (fcnt),
      .rd_data (fill_data),
      .rd_par  (fill_par)
   );

   rbc_phase_mux #(.DW(DW)) u_phase (
      .in_addr  (state_q == ST_ADDR),
      .in_word  (state_q == ST_TURN || state_q == ST_DATA),
      .req      (req_q),
      .ad_out   (bus_ad_out),
      .probe_hi (probe_hi),
      .probe_lo (probe_lo)
   );

   assign busy         = (state_q != ST_IDLE);
   assign addr_strobe  = (state_q == ST_ADDR);
   assign bus_ad_oe    = (state_q == ST_ADDR);
   assign rd_enable    = in_data;
   assign burst_req    = req_q.burst &&
                         (state_q == ST_ADDR || state_q == ST_TURN || state_q == ST_DATA);
   assign word_addr    = wcnt;
   assign berr_flag    = berr_q;
   assign fill_valid   = (state_q == ST_FILL);
   assign fill_idx     = req_q.burst ? fcnt : req_q.addr[CW+1:2];
   assign fill_tag_par = (^req_q.addr[31:TAG_LSB]) ^ ODD_PAR;
endmodule

// File: rtl/rdfill_ctrl_chk.sv
module rdfill_ctrl_chk #(
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          addr_strobe,
   input logic          bus_ad_oe,
   input logic          rd_enable,
   input logic          burst_req,
   input logic          probe_hi,
   input logic          probe_lo,
   input logic          busy,
   input logic [CW-1:0] word_addr,
   input logic          fill_valid,
   input logic          berr_flag
);
   assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> !addr_strobe);

   assert_strobe_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |-> (bus_ad_oe && busy && !rd_enable));

   assert_burst_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe && burst_req) |-> probe_hi);

   assert_idle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (word_addr == '0));

   assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (!rd_enable && !bus_ad_oe && !burst_req && word_addr == '0));

   assert_berr_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      berr_flag |-> (!busy && !fill_valid));

   assert_probe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!probe_hi && !probe_lo));

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> (!rd_enable && !bus_ad_oe));

   assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_enable |-> (!bus_ad_oe && busy));
endmodule

bind rdfill_ctrl rdfill_ctrl_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_strobe (addr_strobe),
   .bus_ad_oe   (bus_ad_oe),
   .rd_enable   (rd_enable),
   .burst_req   (burst_req),
   .probe_hi    (probe_hi),
   .probe_lo    (probe_lo),
   .busy        (busy),
   .word_addr   (word_addr),
   .fill_valid  (fill_valid),
   .berr_flag   (berr_flag)
);

// File: tb/test_rdfill_ctrl.sv
module test_rdfill_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:2] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic        req_miss = 1'b0, req_imiss = 1'b0, cfg_dquad = 1'b0;
   logic        busy;
   logic [31:0] bus_ad_out;
   logic        bus_ad_oe;
   logic [31:0] bus_ad_in = '0;
   logic        addr_strobe, burst_req;
   logic [1:0]  word_addr;
   logic        word_strobe = 1'b0, ack = 1'b0, bus_err = 1'b0;
   logic        rd_enable, probe_hi, probe_lo, berr_flag, fill_valid;
   logic [1:0]  fill_idx;
   logic [31:0] fill_data;
   logic [3:0]  fill_par;
   logic        fill_tag_par;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rdfill_ctrl i_rdfill_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_be(req_be), .req_miss(req_miss), .req_imiss(req_imiss),
      .cfg_dquad(cfg_dquad), .busy(busy), .bus_ad_out(bus_ad_out),
      .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .addr_strobe(addr_strobe),
      .burst_req(burst_req), .word_addr(word_addr), .word_strobe(word_strobe),
      .ack(ack), .bus_err(bus_err), .rd_enable(rd_enable), .probe_hi(probe_hi),
      .probe_lo(probe_lo), .berr_flag(berr_flag), .fill_valid(fill_valid),
      .fill_idx(fill_idx), .fill_data(fill_data), .fill_par(fill_par),
      .fill_tag_par(fill_tag_par)
   );

   function automatic logic exp_burst(input logic m, input logic i, input logic dq);
      return m && (i || dq);
   endfunction

   function automatic logic [3:0] exp_bpar(input logic [31:0] w);
      return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
   endfunction

   function automatic logic exp_tpar(input logic [31:0] a);
      return ^a[31:12];
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [31:0] a, input logic [3:0] be, input logic m,
                          input logic im, input logic dq, input int berr_k,
                          input bit hold_req);
      logic b;
      int n;
      bit late;
      logic [31:0] w [4];
      b = exp_burst(m, im, dq);
      n = b ? 4 : 1;
      late = $urandom_range(0, 1);
      for (int k = 0; k < 4; k++) w[k] = $urandom;

      @(negedge clk);
      req_valid = 1'b1; req_addr = a[31:2]; req_be = be;
      req_miss = m; req_imiss = im; cfg_dquad = dq;
      @(negedge clk);
      if (hold_req) begin
         req_addr = ~a[31:2];
         req_miss = ~m;
      end else begin
         req_valid = 1'b0;
      end
      chk("R1 strobe", addr_strobe, 1'b1);
      chk("R1 oe", bus_ad_oe, 1'b1);
      chk("R1 address word", bus_ad_out, {a[31:4], be});
      chk("R2 burst", burst_req, b);
      chk("R7 probe_hi cause", probe_hi, m);
      chk("R7 probe_lo cause", probe_lo, im);
      chk("R3 start", word_addr, b ? 2'b00 : a[3:2]);
      chk("R8 no enable in address phase", rd_enable, 1'b0);

      @(negedge clk);
      chk("R8 turnaround enable", rd_enable, 1'b0);
      chk("R8 turnaround oe", bus_ad_oe, 1'b0);
      chk("R1 strobe single cycle", addr_strobe, 1'b0);
      chk("R7 probe_hi addr3", probe_hi, a[3]);
      chk("R7 probe_lo addr2", probe_lo, a[2]);
      chk("R2 burst held", burst_req, b);

      @(negedge clk);
      chk("R8 data phase enable", rd_enable, 1'b1);
      for (int k = 0; k < n; k++) begin
         repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            chk("R4 no fill before ack", fill_valid, 1'b0);
         end
         chk("R3 word count", word_addr, b ? 2'(k) : a[3:2]);
         if (k == berr_k) begin
            bus_err = 1'b1;
            @(negedge clk);
            bus_err = 1'b0;
            req_valid = 1'b0;
            chk("R6 flag", berr_flag, 1'b1);
            chk("R6 ended", busy, 1'b0);
            chk("R6 no fill", fill_valid, 1'b0);
            @(negedge clk);
            chk("R6 flag pulse", berr_flag, 1'b0);
            chk("R6 stays idle", busy, 1'b0);
            return;
         end
         word_strobe = 1'b1;
         bus_ad_in = w[k];
         if (k == n - 1 && !(b && late)) ack = 1'b1;
         @(negedge clk);
         word_strobe = 1'b0;
         ack = 1'b0;
         bus_ad_in = $urandom;
      end
      if (b && late) begin
         chk("R3 wrap to 00", word_addr, 2'b00);
         chk("R4 waits for ack", fill_valid, 1'b0);
         chk("R4 still busy", busy, 1'b1);
         ack = 1'b1;
         @(negedge clk);
         ack = 1'b0;
      end
      req_valid = 1'b0;
      for (int f = 0; f < n; f++) begin
         chk("R5 fill valid", fill_valid, 1'b1);
         chk("R5 fill index", fill_idx, b ? 2'(f) : a[3:2]);
         chk("R5 fill data", fill_data, w[b ? f : 0]);
         chk("R5 byte parity", fill_par, exp_bpar(w[b ? f : 0]));
         chk("R5 tag parity", fill_tag_par, exp_tpar(a));
         chk("R3 zero in fill", word_addr, 2'b00);
         @(negedge clk);
      end
      chk("R5 fill length", fill_valid, 1'b0);
      chk("R9 no restart", busy, 1'b0);
      chk("R9 no strobe", addr_strobe, 1'b0);
      chk("R3 idle zero", word_addr, 2'b00);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R3 reset count", word_addr, 2'b00);
      chk("R6 reset flag", berr_flag, 1'b0);
      chk("R5 reset fill", fill_valid, 1'b0);
      chk("R8 reset enable", rd_enable, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle strobe", addr_strobe, 1'b0);
      chk("R7 idle probes", {probe_hi, probe_lo}, 2'b00);

      do_read(32'h1234_5678, 4'hF, 1'b1, 1'b0, 1'b0, -1, 1'b0); // data miss, single
      do_read(32'h8000_0ABC, 4'hF, 1'b1, 1'b0, 1'b1, -1, 1'b0); // data miss, burst
      do_read(32'hBFC0_0004, 4'hF, 1'b1, 1'b1, 1'b0, -1, 1'b0); // instruction miss, burst
      do_read(32'hA000_000C, 4'h3, 1'b0, 1'b1, 1'b1, -1, 1'b0); // uncached, single
      do_read(32'h0F0F_F0F8, 4'hF, 1'b1, 1'b1, 1'b1, 2, 1'b0);  // R6 mid-burst error
      do_read(32'h7654_3210, 4'h1, 1'b0, 1'b0, 1'b0, 0, 1'b0);  // R6 single error
      do_read(32'hCAFE_F00C, 4'hF, 1'b1, 1'b1, 1'b0, -1, 1'b1); // R9 held request

      @(negedge clk);
      bus_err = 1'b1;
      @(negedge clk);
      bus_err = 1'b0;
      chk("R6 idle error ignored", berr_flag, 1'b0);
      chk("R6 idle error no start", busy, 1'b0);

      for (int t = 0; t < 60; t++) begin
         int ek;
         ek = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 3)) : -1;
         do_read($urandom, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ek, 1'($urandom_range(0, 3) == 0));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule